// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside an embedded flash array and watches the bus write cycles aimed at it. Each cycle carries a 16-bit address, 16-bit data and a write strobe. Multi-cycle commands start with a two-write unlock prefix. The third write then picks a command: read-protection mode, temporary block unprotection, a protection register write, or a block erase. Two magic data words, written anywhere in the flash space, change code protection at once without any prefix. Coded addresses are compared on their low 14 bits only, and data is compared on its low byte only.

The block holds the protection register and a temporary copy of it that the unprotect and protect commands act on. In both, 0 means protected: bit 15 guards code and bit N guards block N. The block drives a read-mode select and a protection-register read enable. For erase it gathers a mask of blocks during a timed window that is counted in clock cycles and restarts on every accepted block address. When the window closes it issues a one-cycle erase start. A status byte reports whether the window is open and whether the last protection write was rejected.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock prefix is a write of low data byte A8h to coded address 2A54h followed by a write of low byte 54h to coded address 15A8h. Address bits 15:14 and data bits 15:8 are ignored in these compares.
- R2: A write that does not match the expected step of a sequence returns the decoder to idle with no effect. A later step written alone does nothing.
- R3: After the prefix, a write of low byte 90h to coded address 2A54h sets `readMode` from the next cycle. Any later write clears it.
- R4: While `readMode` is 1, `prRdEn` is 1 during a read (`rdEn`) only when addr[1:0] = 2'b10 (0002h, 0006h, ...). It is 0 for every other address and whenever `readMode` is 0.
- R5: After the prefix, a write of low byte C1h to 2A54h followed by a write of low byte F0h to any address sets the block bits of `tempProt` to 1. Any other fourth write leaves `tempProt` unchanged.
- R6: A single write of FFFFh to any address sets `tempProt[15]` (code unprotected). A write of FFFBh clears it. Either write also aborts any pending sequence, except at the data step of R7.
- R7: After the prefix, a write of low byte C0h to 2A54h makes the next write's full data word the new protection value. If no bit goes from 0 to 1, `prData` and `tempProt` both take that value and `status[5]` is cleared.
- R8: A protection write that would turn any 0 bit of the register back to 1 is rejected. `prData` and `tempProt` keep their values and `status[5]` is set.
- R9: After the prefix, a write of low byte 80h to 2A54h followed by a write of low byte 30h to a block address opens the erase window. `status[3]` = 1 for WIN_CYCLES = CLK_MHZ*TIMEOUT_US cycles, and the block index is addr[13:12].
- R10: Each further low-byte-30h write inside the window adds its block to `eraseMask` and restarts the full window. When the window runs out, `eraseStart` pulses for one cycle and `eraseMask` holds.
- R11: A block whose `tempProt` bit is 0 is never added to `eraseMask`. A write of any other data inside the window aborts: `status[3]` and `eraseMask` clear and no `eraseStart` follows.
- R12: On reset, `prData` and `tempProt` equal PR_INIT (FFFFh), `readMode`, `eraseStart`, `eraseMask` and `status` are 0, and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write cycle strobe |
| rdEn | input | 1 | Read cycle strobe |
| addr | input | 16 | Bus address |
| wdata | input | 16 | Write data |
| readMode | output | 1 | 1 = reads return the protection register |
| prRdEn | output | 1 | Protection-register read enable |
| prData | output | 16 | Stored protection register |
| tempProt | output | 16 | Temporary protection flags (0 = protected) |
| eraseStart | output | 1 | One-cycle erase launch pulse |
| eraseMask | output | NUM_BLOCKS | Blocks selected for erase |
| status | output | 8 | bit 3 window open, bit 5 write error |

## Verification
On every cycle, the assertions check that stored protection bits only move toward 0, that a rejected write leaves the register untouched, that the erase pulse never lasts more than one cycle, that the window count stays bounded and that the control raises at most one action per write. Only the bench scenarios can show the command semantics. These include the partial address and data compares, the aborts that leave no trace, the restart and exact expiry cycle of the erase window, and the skipping of protected blocks. They also include the odd-word-only read enable.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [13:0] KEY_ADDR_A = 14'h2A54;
  localparam logic [13:0] KEY_ADDR_B = 14'h15A8;
  localparam logic [7:0]  KEY_BYTE_A = 8'hA8;
  localparam logic [7:0]  KEY_BYTE_B = 8'h54;
  localparam logic [7:0]  OP_READPROT = 8'h90;
  localparam logic [7:0]  OP_BLKUNP   = 8'hC1;
  localparam logic [7:0]  OP_BLKUNP2  = 8'hF0;
  localparam logic [7:0]  OP_PROTWR   = 8'hC0;
  localparam logic [7:0]  OP_ERASE    = 8'h80;
  localparam logic [7:0]  OP_ERASEBLK = 8'h30;
  localparam logic [15:0] WORD_CODE_UNP = 16'hFFFF;
  localparam logic [15:0] WORD_CODE_PRT = 16'hFFFB;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_BTU, S_WPR, S_ERS, S_WIN
  } seqState_t;

  typedef struct packed {
    logic setRpm;
    logic btuDone;
    logic wprWrite;
    logic codeUnprot;
    logic codeProt;
    logic ersFirst;
    logic ersMore;
    logic ersAbort;
  } ctlStrobe_t;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        winOpen,
  output ctlStrobe_t  strobe
);

  seqState_t state, stateNext, stateEff;

  logic [13:0] codedAddr;
  logic [7:0]  lowByte;
  logic        isUnp, isPrt, isCode, atA, atB;

  assign codedAddr = addr[13:0];
  assign lowByte   = wdata[7:0];
  assign isUnp     = (wdata == WORD_CODE_UNP);
  assign isPrt     = (wdata == WORD_CODE_PRT);
  assign isCode    = isUnp | isPrt;
  assign atA       = (codedAddr == KEY_ADDR_A);
  assign atB       = (codedAddr == KEY_ADDR_B);

  // A closed window behaves as idle in the same cycle.
  assign stateEff = (state == S_WIN && !winOpen) ? S_IDLE : state;

  always_comb begin
    strobe    = '0;
    stateNext = stateEff;
    if (wrEn) begin
      stateNext = S_IDLE;
      if (stateEff == S_WPR) begin
        strobe.wprWrite = 1'b1;
      end else if (isCode) begin
        strobe.codeUnprot = isUnp;
        strobe.codeProt   = isPrt;
        strobe.ersAbort   = (stateEff == S_WIN);
      end else begin
        unique case (stateEff)
          S_IDLE: if (atA && lowByte == KEY_BYTE_A) stateNext = S_UNL1;
          S_UNL1: if (atB && lowByte == KEY_BYTE_B) stateNext = S_UNL2;
          S_UNL2: begin
            if (atA) begin
              unique case (lowByte)
                OP_READPROT: strobe.setRpm = 1'b1;
                OP_BLKUNP:   stateNext = S_BTU;
                OP_PROTWR:   stateNext = S_WPR;
                OP_ERASE:    stateNext = S_ERS;
                default:     stateNext = S_IDLE;
              endcase
            end
          end
          S_BTU: if (lowByte == OP_BLKUNP2) strobe.btuDone = 1'b1;
          S_ERS: if (lowByte == OP_ERASEBLK) begin
            strobe.ersFirst = 1'b1;
            stateNext       = S_WIN;
          end
          S_WIN: begin
            if (lowByte == OP_ERASEBLK) begin
              strobe.ersMore = 1'b1;
              stateNext      = S_WIN;
            end else begin
              strobe.ersAbort = 1'b1;
            end
          end
          default: stateNext = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R2: one write triggers at most one action
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setRpm, strobe.btuDone, strobe.wprWrite, strobe.codeUnprot,
              strobe.codeProt, strobe.ersFirst, strobe.ersMore}));

  // R2: without a write, no action is raised
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe == '0));

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int          NUM_BLOCKS = 4,
  parameter int          BLK_LSB    = 12,
  parameter int          WIN_CYCLES = 19200,
  parameter logic [15:0] PR_INIT    = 16'hFFFF
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [15:0]           addr,
  input  logic [15:0]           wdata,
  input  ctlStrobe_t            strobe,
  output logic                  winOpen,
  output logic                  readMode,
  output logic                  prRdEn,
  output logic [15:0]           prData,
  output logic [15:0]           tempProt,
  output logic                  eraseStart,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic [7:0]            status
);

  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES);

  logic [15:0]           protReg;
  logic                  writeErr;
  logic                  rpm;
  logic [CNT_W-1:0]      winCnt;
  logic [BLK_W-1:0]      blkIdx;
  logic [NUM_BLOCKS-1:0] blkBit;
  logic                  blkAllowed;
  logic                  wprReject;
  logic                  winLoad;

  assign blkIdx     = addr[BLK_LSB +: BLK_W];
  assign blkAllowed = tempProt[blkIdx];
  assign wprReject  = |(~protReg & wdata);
  assign winLoad    = strobe.ersFirst | strobe.ersMore;

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blkDec
      assign blkBit[b] = (blkIdx == BLK_W'(b)) && blkAllowed;
    end
  endgenerate

  // protection register, temporary flags, write error
  always_ff @(posedge clk) begin
    if (!rstN) begin
      protReg  <= PR_INIT;
      tempProt <= PR_INIT;
      writeErr <= 1'b0;
    end else begin
      if (strobe.wprWrite) begin
        writeErr <= wprReject;
        if (!wprReject) begin
          protReg  <= wdata;
          tempProt <= wdata;
        end
      end
      if (strobe.btuDone)    tempProt[NUM_BLOCKS-1:0] <= '1;
      if (strobe.codeUnprot) tempProt[15] <= 1'b1;
      if (strobe.codeProt)   tempProt[15] <= 1'b0;
    end
  end

  // read-protection mode
  always_ff @(posedge clk) begin
    if (!rstN)              rpm <= 1'b0;
    else if (strobe.setRpm) rpm <= 1'b1;
    else if (wrEn)          rpm <= 1'b0;
  end

  // erase window and block mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt     <= '0;
      eraseMask  <= '0;
      eraseStart <= 1'b0;
    end else begin
      eraseStart <= 1'b0;
      if (strobe.ersAbort) begin
        winCnt    <= '0;
        eraseMask <= '0;
      end else if (winLoad) begin
        winCnt    <= WIN_LOAD;
        eraseMask <= strobe.ersFirst ? blkBit : (eraseMask | blkBit);
      end else if (winCnt != '0) begin
        winCnt <= winCnt - 1'b1;
        if (winCnt == CNT_W'(1)) eraseStart <= 1'b1;
      end
    end
  end

  assign winOpen  = (winCnt != '0);
  assign readMode = rpm;
  assign prRdEn   = rpm & rdEn & (addr[1:0] == 2'b10);
  assign prData   = protReg;
  assign status   = {2'b00, writeErr, 1'b0, winOpen, 3'b000};

  // R7: stored protection bits never return from 0 to 1
  a_r7_no_reprogram: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(protReg) & protReg) == '0));

  // R8: a rejected write leaves the register as it was
  a_r8_reject_keeps: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeErr) |-> $stable(protReg));

  // R10: the erase launch is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  // R9: the window count never exceeds its load value
  a_r9_window_bounded: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_LOAD);

  // R11: an abort closes the window on the next cycle
  a_r11_abort_closes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ersAbort |=> (!winOpen && eraseMask == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          NUM_BLOCKS = 4,
  parameter int          BLK_LSB    = 12,
  parameter int          CLK_MHZ    = 200,
  parameter int          TIMEOUT_US = 96,
  parameter logic [15:0] PR_INIT    = 16'hFFFF
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [15:0]           addr,
  input  logic [15:0]           wdata,
  output logic                  readMode,
  output logic                  prRdEn,
  output logic [15:0]           prData,
  output logic [15:0]           tempProt,
  output logic                  eraseStart,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic [7:0]            status
);

  localparam int WIN_CYCLES = CLK_MHZ * TIMEOUT_US;

  ctlStrobe_t strobe;
  logic       winOpen;

  fcd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wdata   (wdata),
    .winOpen (winOpen),
    .strobe  (strobe)
  );

  fcd_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_LSB    (BLK_LSB),
    .WIN_CYCLES (WIN_CYCLES),
    .PR_INIT    (PR_INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addr       (addr),
    .wdata      (wdata),
    .strobe     (strobe),
    .winOpen    (winOpen),
    .readMode   (readMode),
    .prRdEn     (prRdEn),
    .prData     (prData),
    .tempProt   (tempProt),
    .eraseStart (eraseStart),
    .eraseMask  (eraseMask),
    .status     (status)
  );

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int WIN = 200 * 96;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        readMode, prRdEn, eraseStart;
  logic [15:0] prData, tempProt;
  logic [3:0]  eraseMask;
  logic [7:0]  status;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .readMode(readMode), .prRdEn(prRdEn), .prData(prData), .tempProt(tempProt),
    .eraseStart(eraseStart), .eraseMask(eraseMask), .status(status)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 16'h0100; wdata = '0;
  endtask

  task automatic prefix();
    busWr(16'hEA54, 16'h33A8);   // R1: upper address and data bits set
    busWr(16'h55A8, 16'hCC54);
  endtask

  task automatic t_reset();
    check(readMode == 1'b0, "R12 readMode", readMode, 0);
    check(status == 8'h00, "R12 status", status, 0);
    check(tempProt == 16'hFFFF, "R12 tempProt", tempProt, 16'hFFFF);
    check(prData == 16'hFFFF, "R12 prData", prData, 16'hFFFF);
    check(eraseMask == 4'h0 && eraseStart == 1'b0, "R12 erase", {eraseMask, eraseStart}, 0);
  endtask

  task automatic rdProbe(input logic [15:0] a, input bit exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check(prRdEn == exp, req, prRdEn, exp);
    rdEn = 1'b0; addr = 16'h0100;
  endtask

  task automatic t_readProt();
    prefix();
    busWr(16'h2A54, 16'h0090);
    check(readMode == 1'b1, "R1/R3 enter read mode", readMode, 1);
    rdProbe(16'h0006, 1'b1, "R4 odd word 0006");
    rdProbe(16'h0002, 1'b1, "R4 odd word 0002");
    rdProbe(16'h0004, 1'b0, "R4 even word 0004");
    rdProbe(16'h0003, 1'b0, "R4 byte 0003");
    busWr(16'h0010, 16'h1234);
    check(readMode == 1'b0, "R3 cleared by write", readMode, 0);
    rdProbe(16'h0006, 1'b0, "R4 no enable outside mode");
  endtask

  task automatic t_abort();
    prefix();
    busWr(16'h2A54, 16'h0077);
    busWr(16'h2A54, 16'h0090);
    check(readMode == 1'b0, "R2 bad third step", readMode, 0);
    busWr(16'h2A54, 16'h00A8);
    busWr(16'h0000, 16'h0054);
    busWr(16'h15A8, 16'h0054);
    busWr(16'h2A54, 16'h0090);
    check(readMode == 1'b0, "R2 bad second step", readMode, 0);
    busWr(16'h2A55, 16'h00A8);
    busWr(16'h15A8, 16'h0054);
    busWr(16'h2A54, 16'h0090);
    check(readMode == 1'b0, "R1 wrong coded address", readMode, 0);
  endtask

  task automatic t_code();
    busWr(16'h4321, 16'hFFFB);
    check(tempProt[15] == 1'b0, "R6 code protect", tempProt, 16'h7FFF);
    busWr(16'h8000, 16'hFFFF);
    check(tempProt[15] == 1'b1, "R6 code unprotect", tempProt, 16'hFFFF);
    prefix();
    busWr(16'h1000, 16'hFFFB);
    busWr(16'h2A54, 16'h0090);
    check(readMode == 1'b0 && tempProt[15] == 1'b0, "R6 abort plus protect",
          {readMode, tempProt}, 0);
    busWr(16'h1000, 16'hFFFF);
  endtask

  task automatic wpr(input logic [15:0] v);
    prefix();
    busWr(16'h2A54, 16'h00C0);
    busWr(16'h0ABC, v);
  endtask

  task automatic t_protWrite();
    wpr(16'hFFFE);
    check(prData == 16'hFFFE && tempProt == 16'hFFFE, "R7 accept", prData, 16'hFFFE);
    check(status[5] == 1'b0, "R7 no error", status, 0);
    wpr(16'hFFFF);
    check(status[5] == 1'b1, "R8 error flag", status, 8'h20);
    check(prData == 16'hFFFE, "R8 register kept", prData, 16'hFFFE);
    wpr(16'h7FFC);
    check(prData == 16'h7FFC && tempProt == 16'h7FFC, "R7 second accept", prData, 16'h7FFC);
    check(status[5] == 1'b0, "R7 error cleared", status, 0);
    busWr(16'h0000, 16'hFFFF);
    check(tempProt == 16'hFFFC, "R6 code temp unprotect", tempProt, 16'hFFFC);
  endtask

  task automatic t_erase();
    prefix();
    busWr(16'h2A54, 16'h0080);
    busWr(16'h3000, 16'h0030);
    check(status[3] == 1'b1, "R9 window open", status, 8'h08);
    check(eraseMask == 4'b1000, "R9 first block", eraseMask, 4'b1000);
    repeat (100) @(posedge clk);
    busWr(16'hE000, 16'h1130);
    check(eraseMask == 4'b1100, "R10 add block", eraseMask, 4'b1100);
    busWr(16'h0000, 16'h0030);
    check(eraseMask == 4'b1100, "R11 protected block skipped", eraseMask, 4'b1100);
    repeat (WIN - 1) @(posedge clk);
    @(negedge clk);
    check(status[3] == 1'b1 && eraseStart == 1'b0, "R10 restart holds window",
          {status, 7'd0, eraseStart}, 16'h0800);
    @(negedge clk);
    check(status[3] == 1'b0 && eraseStart == 1'b1, "R10 expiry pulse",
          {status, 7'd0, eraseStart}, 16'h0001);
    @(negedge clk);
    check(eraseStart == 1'b0 && eraseMask == 4'b1100, "R10 pulse ends, mask held",
          {eraseMask, eraseStart}, 5'b11000);
    prefix();
    busWr(16'h2A54, 16'h0080);
    busWr(16'h2000, 16'h0030);
    busWr(16'h2000, 16'h0055);
    check(status[3] == 1'b0 && eraseMask == 4'b0000, "R11 abort clears",
          {status, 4'd0, eraseMask}, 0);
    begin
      bit seen = 1'b0;
      repeat (50) begin
        @(negedge clk);
        if (eraseStart) seen = 1'b1;
      end
      check(!seen, "R11 no pulse after abort", seen, 0);
    end
  endtask

  task automatic t_blockUnprot();
    prefix();
    busWr(16'h2A54, 16'h00C1);
    busWr(16'h0000, 16'h00F1);
    check(tempProt == 16'hFFFC, "R5 wrong fourth write", tempProt, 16'hFFFC);
    prefix();
    busWr(16'h2A54, 16'h00C1);
    busWr(16'h7777, 16'h22F0);
    check(tempProt == 16'hFFFF, "R5 blocks unprotected", tempProt, 16'hFFFF);
    check(prData == 16'h7FFC, "R5 register untouched", prData, 16'h7FFC);
  endtask

  task automatic t_resetAgain();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(tempProt == 16'hFFFF && prData == 16'hFFFF, "R12 reset restores",
          {prData, tempProt}, 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readProt();
    t_abort();
    t_code();
    t_protWrite();
    t_erase();
    t_blockUnprot();
    t_resetAgain();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule